// File: doc/BRIEF.md
# Data-Dependent-Latency Sequential Multiplier

This block multiplies a 16-bit multiplicand by a 16-bit source operand over many clock cycles, in either unsigned or two's-complement signed mode. Its purpose is to reproduce the timing of an old microcoded multiply. The completion pulse does not arrive after a fixed delay. It arrives after a base count of 38 clocks plus 2 clocks for every nonzero digit the source operand contributes.

In unsigned mode, every 1 bit of the source is one costly digit. In signed mode, the source is recoded radix-2 Booth style. A 0 is placed below its least significant bit, and every adjacent bit pair in the resulting 17-bit value that differs (01 or 10) costs one add or subtract. A zero digit costs no time.

A caller pulses the start input with the operands and the mode, then waits for the done pulse. The product register then holds the result until the next accepted start. The arithmetic itself finishes early. The block holds the result back until the modelled clock count has run out, so the done pulse lands on exactly the predicted cycle.

Top module: `vlat_mult`

## Requirements
- R1: After a synchronous reset, busy is 0, done is 0 and the product is 0.
- R2: Unsigned mode (signed_mode=0): if start is sampled at clock edge k while the block is idle, done is high right after edge k+38+2n, and never earlier. Here n is the number of 1 bits in the 16-bit source.
- R3: Signed mode (signed_mode=1): the same timing holds, but n is the number of positions i in 0..15 where src[i] differs from the bit below it, with bit -1 taken as 0.
- R4: In unsigned mode the product is the 32-bit unsigned product of the two operands.
- R5: In signed mode the product is the 32-bit two's-complement product of the two operands, each read as a signed 16-bit value.
- R6: busy is high from the edge that accepts a start until the edge that raises done. It falls on that same edge.
- R7: done is high for exactly one clock per accepted start.
- R8: A start that arrives while busy is high is ignored. The running operation's latency and product do not change, even if the operands at that moment differ.
- R9: The product output changes only on the edge that raises done, and otherwise holds its value.
- R10: The longest latency is 70 clocks. It occurs for source 0x5555 in signed mode and for source 0xFFFF in unsigned mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | 16 | Multiplicand |
| src | input | 16 | Source operand; its bit pattern sets the latency |
| product | output | 32 | Registered result, held until the next done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong latency budget shows up as a done pulse that arrives early or late by a multiple of two clocks. The bench catches this on the very first operation whose source has a given digit count, because it counts every edge from the accepting edge to done. A wrong Booth step or operand extension corrupts the product. This is visible at done for any source with a transition in the affected position, and the single-bit sources and the alternating patterns expose each bit position in turn. A start leaking through while busy would restart the budget, so the done pulse would come late and the product would change.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/mul_cost.sv
module mul_cost #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int STEP = 2,
  parameter int CW   = 7
) (
  input  logic [W-1:0]  src,
  input  logic          sgn,
  output logic [CW-1:0] lat_m1
);
  localparam int NW = $clog2(W + 1);

  logic [W-1:0]  nz;
  logic [NW-1:0] n;

  generate
    for (genvar i = 0; i < W; i++) begin : g_dig
      if (i == 0) begin : g_lsb
        assign nz[i] = src[0];
      end else begin : g_up
        assign nz[i] = sgn ? (src[i] ^ src[i-1]) : src[i];
      end
    end
  endgenerate

  always_comb begin
    n      = NW'($countones(nz));
    lat_m1 = CW'(BASE - 1) + CW'(STEP) * CW'(n);
  end
endmodule

// File: rtl/mul_timer.sv
module mul_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= load_val;
    end else if (expire) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mul_booth_dp.sv
module mul_booth_dp #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sgn,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   src,
  output logic [2*W-1:0] acc
);
  localparam int IW = $clog2(W + 1);

  logic [2*W-1:0] mx_q;
  logic [W-1:0]   sq_q;
  logic           prev_q;
  logic           sgn_q;
  logic [IW-1:0]  idx_q;
  logic           run;
  logic           do_add, do_sub;

  assign run    = (idx_q < IW'(W));
  assign do_add = sgn_q ? (!sq_q[0] && prev_q) : sq_q[0];
  assign do_sub = sgn_q && sq_q[0] && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mx_q   <= '0;
      sq_q   <= '0;
      prev_q <= 1'b0;
      sgn_q  <= 1'b0;
      idx_q  <= IW'(W);
    end else if (load) begin
      acc    <= '0;
      mx_q   <= sgn ? {{W{mcand[W-1]}}, mcand} : {{W{1'b0}}, mcand};
      sq_q   <= src;
      prev_q <= 1'b0;
      sgn_q  <= sgn;
      idx_q  <= '0;
    end else if (run) begin
      if (do_add)      acc <= acc + mx_q;
      else if (do_sub) acc <= acc - mx_q;
      mx_q   <= mx_q << 1;
      sq_q   <= sq_q >> 1;
      prev_q <= sq_q[0];
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/vlat_mult.sv
module vlat_mult #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int STEP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   src,
  output logic [2*W-1:0] product,
  output logic           busy,
  output logic           done
);
  import vmul_pkg::*;

  localparam int MAXL = BASE + STEP * W;
  localparam int CW   = $clog2(MAXL + 1);

  logic          accept;
  logic          expire;
  logic [CW-1:0] lat_m1;
  logic [2*W-1:0] acc;
  mul_mode_e     mode;

  assign mode   = mul_mode_e'(signed_mode);
  assign accept = start && !busy;

  mul_cost #(.W(W), .BASE(BASE), .STEP(STEP), .CW(CW)) u_cost (
    .src    (src),
    .sgn    (mode == MODE_SIGNED),
    .lat_m1 (lat_m1)
  );

  mul_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (lat_m1),
    .busy     (busy),
    .expire   (expire)
  );

  mul_booth_dp #(.W(W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .sgn   (mode == MODE_SIGNED),
    .mcand (mcand),
    .src   (src),
    .acc   (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= expire;
      if (expire) product <= acc;
    end
  end
endmodule

// File: rtl/vlat_mult_chk.sv
module vlat_mult_chk #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int STEP = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2*W-1:0] product,
  input logic           busy,
  input logic           done
);
  localparam int MAXL = BASE + STEP * W;
  localparam int KW   = $clog2(MAXL + 2) + 1;

  logic [KW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst)                elapsed <= '0;
    else if (start && !busy) elapsed <= '0;
    else if (busy)          elapsed <= elapsed + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !done && product == '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r9_product_hold: assert property (@(posedge clk) disable iff (rst) !$stable(product) |-> done);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> (busy || done));
  a_r10_latency_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (elapsed >= KW'(BASE) && elapsed <= KW'(MAXL)));
endmodule

bind vlat_mult vlat_mult_chk #(.W(W), .BASE(BASE), .STEP(STEP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .product (product),
  .busy    (busy),
  .done    (done)
);

// File: tb/vlat_mult_tb.sv
module vlat_mult_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [15:0] mcand = '0;
  logic [15:0] src = '0;
  logic [31:0] product;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  vlat_mult u_dut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .mcand(mcand), .src(src), .product(product), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [15:0] b, input bit s);
    int n = 0;
    for (int i = 0; i < 16; i++) begin
      if (s) n += (b[i] != ((i == 0) ? 1'b0 : b[i-1])) ? 1 : 0;
      else   n += b[i] ? 1 : 0;
    end
    return 38 + 2 * n;
  endfunction

  function automatic logic [31:0] exp_prod(input logic [15:0] a, input logic [15:0] b, input bit s);
    logic signed [31:0] sa, sb;
    if (s) begin
      sa = $signed({{16{a[15]}}, a});
      sb = $signed({{16{b[15]}}, b});
      return sa * sb;
    end
    return {16'h0, a} * {16'h0, b};
  endfunction

  // run one operation; disturb != 0 pulses start with other operands mid-flight (R8)
  task automatic run(input logic [15:0] a, input logic [15:0] b, input bit s, input bit disturb);
    int n = 0;
    int lat = exp_lat(b, s);
    logic [31:0] pe = exp_prod(a, b, s);
    bit   busy_ok = 1'b1;
    string rl = s ? "R3" : "R2";
    string rp = s ? "R5" : "R4";
    @(negedge clk);
    start = 1'b1; mcand = a; src = b; signed_mode = s;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after accept", {31'b0, busy}, 32'h1);
    while (n < 200) begin
      if (disturb && n == 5) begin
        start = 1'b1; mcand = ~a; src = 16'h5555; signed_mode = ~s;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done === 1'b1) break;
      if (busy !== 1'b1) busy_ok = 1'b0;
    end
    start = 1'b0;
    chk(n == lat, disturb ? "R8 latency" : rl, n, lat);
    chk(product === pe, disturb ? "R8 product" : rp, product, pe);
    chk(busy_ok && busy === 1'b0, "R6 busy span", {31'b0, busy}, 32'h0);
  endtask

  logic [15:0] corner [5] = '{16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h8000};

  initial begin
    logic [15:0] lf;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 32'h0, "R1 reset state", product, 32'h0);
    rst = 1'b0;

    // R10: worst-case sources
    for (int s = 0; s < 2; s++) begin
      chk(exp_lat(s ? 16'h5555 : 16'hFFFF, s[0]) == 70, "R10 model", 0, 70);
      run(16'h1234, s ? 16'h5555 : 16'hFFFF, s[0], 1'b0);
    end

    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(corner[i], corner[j], s[0], 1'b0);

    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++)
        run(16'hBEEF, 16'(1 << i), s[0], 1'b0);

    // R8: start during busy
    run(16'h7FFF, 16'h0001, 1'b0, 1'b1);
    run(16'h8001, 16'h00F0, 1'b1, 1'b1);

    // R7 / R9: done one cycle, product held for an idle stretch
    run(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    held = product;
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R7 done single pulse", {31'b0, done}, 32'h0);
    mcand = 16'h1111; src = 16'h2222;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(product === held, "R9 product held", product, held);

    lf = 16'hACE1;
    for (int k = 0; k < 500; k++) begin
      logic [15:0] ra, rb;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ra = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rb = lf;
      run(ra, rb, k[0], 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule